// File: doc/BRIEF.md
# Split integer and address issue queue

This block sits between dispatch and the execution ports of an out-of-order core. Each cycle it can take up to four dispatched instructions. A per-slot flag sends each one to one of two queues. The integer queue may send any waiting instruction whose operands are ready. It picks up to two per cycle, oldest first, one for each of the two ALU ports. The address queue sends work to a single load/store port, and only from its head, so memory operations leave in program order.

Both queues check operand readiness against one shared scoreboard, which holds one busy bit per register tag. An accepted instruction marks its destination tag busy. A result broadcast clears that bit again, and any entry that was waiting on it can issue in the following cycle. Each queue reports how many entries it has free, and dispatch uses these counts to limit what it sends. A flush empties both queues and clears the scoreboard. Only tags, instruction ids and readiness are tracked. Data values are not.

Top module: `split_issue_queue`

## Requirements
- R1: While reset is active, and right after it, both free counts equal the queue depth (8), and no issue valid is high.
- R2: The integer queue issues any ready entry whatever its age, so a blocked older entry does not hold back a younger ready one.
- R3: The integer queue issues at most two entries per cycle. When more than two are ready it takes the two oldest: ALU port 0 gets the oldest and port 1 the next. Port 1 is never valid without port 0, and the two never carry the same id.
- R4: The address queue issues only its head entry, on the single load/store port. A ready younger entry waits while the head is blocked.
- R5: An entry is ready when neither source tag is busy in the shared scoreboard. An accepted dispatch marks its destination tag busy from the next cycle on.
- R6: A broadcast of a tag clears its busy bit at the end of that cycle. An entry waiting on that tag issues in the next cycle at the earliest, never in the broadcast cycle itself.
- R7: Dispatch has four slots, and each slot carries a flag: 1 sends it to the address queue, 0 to the integer queue. A lower slot is older than a higher slot in the same cycle. An entry can be selected from the cycle after it is inserted.
- R8: Each free count equals 8 minus the queue's occupancy. It changes in the cycle after an insertion or an issue, and an issued entry leaves at the end of its issue cycle.
- R9: A slot is accepted only while its target queue still has room under the free count reported in that cycle, counting earlier accepted slots to the same queue. Other slots are ignored, with no entry and no scoreboard change.
- R10: Flush suppresses every issue valid in its cycle and ignores dispatch in that cycle. From the next cycle both queues are empty, both free counts are 8, and every register tag reads ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty both queues and clear the scoreboard |
| disp_vld_i | input | 4 | Per-slot dispatch valid |
| disp_mem_i | input | 4 | Per-slot target: 1 address queue, 0 integer queue |
| disp_id_i | input | 4x8 | Per-slot instruction id |
| disp_src_a_i | input | 4x5 | Per-slot first source tag |
| disp_src_b_i | input | 4x5 | Per-slot second source tag |
| disp_dst_i | input | 4x5 | Per-slot destination tag |
| wb_vld_i | input | 2 | Result broadcast valids |
| wb_tag_i | input | 2x5 | Result broadcast tags |
| alu_vld_o | output | 2 | Issue valid for ALU ports 0 and 1 |
| alu_id_o | output | 2x8 | Issued id per ALU port |
| alu_dst_o | output | 2x5 | Issued destination tag per ALU port |
| ls_vld_o | output | 1 | Issue valid for the load/store port |
| ls_id_o | output | 8 | Issued id on the load/store port |
| ls_dst_o | output | 5 | Issued destination tag on the load/store port |
| int_free_o | output | 4 | Free entries in the integer queue |
| adr_free_o | output | 4 | Free entries in the address queue |

## Verification
The bench blocks an older integer entry behind a younger ready one. A design that keeps strict age order would stall the younger entry, and one that picks from the wrong end would put the ids on the wrong ALU ports. It holds a ready load/store entry behind a blocked head, which catches a queue that lets the younger one pass. It fills the integer queue through a partial acceptance and then over-dispatches. If the admission check were wrong, dropped ids would issue later, or the free count would drift from zero. Broadcast timing and flush are checked cycle by cycle: an entry waking in the broadcast cycle itself, a flush that leaks an issue, or a flush that leaves a stale busy bit all show up as mismatches.

// File: rtl/isq_pkg.sv
`timescale 1ns/1ps
package isq_pkg;
  localparam int unsigned TAG_W = 5;
  localparam int unsigned ID_W  = 8;
  localparam int unsigned NREG  = 1 << TAG_W;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [ID_W-1:0]  iid_t;

  typedef struct packed {
    iid_t id;
    tag_t src_a;
    tag_t src_b;
    tag_t dst;
  } isq_ent_t;
endpackage

// File: rtl/isq_scoreboard.sv
`timescale 1ns/1ps
module isq_scoreboard
  import isq_pkg::*;
#(
  parameter int unsigned SET_W = 4,
  parameter int unsigned CLR_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic [SET_W-1:0]       set_vld_i,
  input  tag_t [SET_W-1:0]       set_tag_i,
  input  logic [CLR_W-1:0]       clr_vld_i,
  input  tag_t [CLR_W-1:0]       clr_tag_i,
  output logic [NREG-1:0]        busy_o
);
  logic [NREG-1:0]  busy_q, busy_d;
  logic [CLR_W-1:0] clr_hits_set;

  always_comb begin
    busy_d = busy_q;
    for (int c = 0; c < CLR_W; c++)
      if (clr_vld_i[c]) busy_d[clr_tag_i[c]] = 1'b0;
    // a new allocation wins over a broadcast of the same tag
    for (int s = 0; s < SET_W; s++)
      if (set_vld_i[s]) busy_d[set_tag_i[s]] = 1'b1;
  end

  always_comb begin
    for (int c = 0; c < CLR_W; c++) begin
      clr_hits_set[c] = 1'b0;
      for (int s = 0; s < SET_W; s++)
        if (set_vld_i[s] && set_tag_i[s] == clr_tag_i[c]) clr_hits_set[c] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= '0;
    else if (flush_i) busy_q <= '0;
    else              busy_q <= busy_d;
  end

  assign busy_o = busy_q;

  for (genvar c = 0; c < CLR_W; c++) begin : g_clr_chk
    AST_WAKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_vld_i[c] && !clr_hits_set[c] |=> !busy_q[$past(clr_tag_i[c])]); // R6
  end

  for (genvar s = 0; s < SET_W; s++) begin : g_set_chk
    AST_ALLOC_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_vld_i[s] && !flush_i |=> busy_q[$past(set_tag_i[s])]); // R5
  end

  AST_FLUSH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> busy_q == '0); // R10
endmodule

// File: rtl/isq_route.sv
`timescale 1ns/1ps
module isq_route
  import isq_pkg::*;
#(
  parameter int unsigned DISP_W = 4,
  parameter int unsigned INT_FW = 4,
  parameter int unsigned ADR_FW = 4,
  localparam int unsigned CNT_W = $clog2(DISP_W + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DISP_W-1:0]     disp_vld_i,
  input  logic [DISP_W-1:0]     disp_mem_i,
  input  isq_ent_t [DISP_W-1:0] disp_ent_i,
  input  logic [INT_FW-1:0]     int_free_i,
  input  logic [ADR_FW-1:0]     adr_free_i,
  output logic [DISP_W-1:0]     acc_o,
  output logic [CNT_W-1:0]      int_cnt_o,
  output isq_ent_t [DISP_W-1:0] int_ent_o,
  output logic [CNT_W-1:0]      adr_cnt_o,
  output isq_ent_t [DISP_W-1:0] adr_ent_o
);
  int ni, na;
  int rank [DISP_W];

  always_comb begin
    ni = 0;
    na = 0;
    for (int j = 0; j < DISP_W; j++) begin
      rank[j] = disp_mem_i[j] ? na : ni;
      if (disp_mem_i[j]) acc_o[j] = disp_vld_i[j] && (na < int'(adr_free_i));
      else               acc_o[j] = disp_vld_i[j] && (ni < int'(int_free_i));
      if (acc_o[j]) begin
        if (disp_mem_i[j]) na = na + 1;
        else               ni = ni + 1;
      end
    end
    for (int p = 0; p < DISP_W; p++) begin
      int_ent_o[p] = '0;
      adr_ent_o[p] = '0;
      for (int j = 0; j < DISP_W; j++) begin
        if (acc_o[j] && !disp_mem_i[j] && rank[j] == p) int_ent_o[p] = disp_ent_i[j];
        if (acc_o[j] &&  disp_mem_i[j] && rank[j] == p) adr_ent_o[p] = disp_ent_i[j];
      end
    end
    int_cnt_o = CNT_W'(ni);
    adr_cnt_o = CNT_W'(na);
  end

  AST_INT_ADMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(int_cnt_o) <= int'(int_free_i)); // R9
  AST_ADR_ADMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(adr_cnt_o) <= int'(adr_free_i)); // R9
endmodule

// File: rtl/isq_queue.sv
`timescale 1ns/1ps
module isq_queue
  import isq_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned INS_W    = 4,
  parameter int unsigned ISS_W    = 2,
  parameter bit          IN_ORDER = 1'b0,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned IW = $clog2(INS_W + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic [IW-1:0]        ins_cnt_i,
  input  isq_ent_t [INS_W-1:0] ins_ent_i,
  input  logic [NREG-1:0]      busy_i,
  output logic [ISS_W-1:0]     iss_vld_o,
  output isq_ent_t [ISS_W-1:0] iss_ent_o,
  output logic [CW-1:0]        free_o
);
  isq_ent_t         ent_q [DEPTH];
  isq_ent_t         ent_d [DEPTH];
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DEPTH-1:0] occ, rdy, sel, keep;
  int               posn [DEPTH];
  int               kept;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      occ[i] = i < int'(cnt_q);
      rdy[i] = occ[i] && !busy_i[ent_q[i].src_a] && !busy_i[ent_q[i].src_b];
    end
  end

  if (IN_ORDER) begin : g_head
    always_comb begin
      sel    = '0;
      sel[0] = rdy[0];
      for (int k = 0; k < ISS_W; k++) begin
        iss_vld_o[k] = (k == 0) && rdy[0] && !flush_i;
        iss_ent_o[k] = ent_q[0];
      end
    end
  end else begin : g_any
    int pre [DEPTH];
    int nrdy;
    always_comb begin
      nrdy = 0;
      for (int i = 0; i < DEPTH; i++) begin
        pre[i] = nrdy;
        sel[i] = rdy[i] && (nrdy < ISS_W);
        if (rdy[i]) nrdy = nrdy + 1;
      end
      for (int k = 0; k < ISS_W; k++) begin
        iss_vld_o[k] = 1'b0;
        iss_ent_o[k] = '0;
        for (int i = 0; i < DEPTH; i++)
          if (sel[i] && pre[i] == k) begin
            iss_vld_o[k] = !flush_i;
            iss_ent_o[k] = ent_q[i];
          end
      end
    end

    if (ISS_W > 1) begin : g_pack_chk
      AST_PORT_PACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss_vld_o[1] |-> iss_vld_o[0]); // R3
    end
  end

  // survivors slide toward index 0, new entries append behind them
  always_comb begin
    kept = 0;
    for (int i = 0; i < DEPTH; i++) begin
      keep[i] = occ[i] && !sel[i];
      posn[i] = kept;
      if (keep[i]) kept = kept + 1;
    end
    for (int p = 0; p < DEPTH; p++) begin
      ent_d[p] = '0;
      for (int i = 0; i < DEPTH; i++)
        if (keep[i] && posn[i] == p) ent_d[p] = ent_q[i];
      for (int k = 0; k < INS_W; k++)
        if (k < int'(ins_cnt_i) && kept + k == p) ent_d[p] = ins_ent_i[k];
    end
    cnt_d = CW'(kept + int'(ins_cnt_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end

  assign free_o = CW'(DEPTH) - cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= DEPTH); // R9
  AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> iss_vld_o == '0); // R10
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> free_o == CW'(DEPTH)); // R10

  for (genvar k = 0; k < ISS_W; k++) begin : g_rdy_chk
    AST_ISSUE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_vld_o[k] |-> !busy_i[iss_ent_o[k].src_a] && !busy_i[iss_ent_o[k].src_b]); // R5
  end
endmodule

// File: rtl/split_issue_queue.sv
`timescale 1ns/1ps
module split_issue_queue
  import isq_pkg::*;
#(
  parameter int unsigned DISP_W    = 4,
  parameter int unsigned WB_W      = 2,
  parameter int unsigned ALU_N     = 2,
  parameter int unsigned INT_DEPTH = 8,
  parameter int unsigned ADR_DEPTH = 8,
  localparam int unsigned INT_FW = $clog2(INT_DEPTH + 1),
  localparam int unsigned ADR_FW = $clog2(ADR_DEPTH + 1),
  localparam int unsigned CNT_W  = $clog2(DISP_W + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              flush_i,
  input  logic [DISP_W-1:0]                 disp_vld_i,
  input  logic [DISP_W-1:0]                 disp_mem_i,
  input  logic [DISP_W-1:0][ID_W-1:0]       disp_id_i,
  input  logic [DISP_W-1:0][TAG_W-1:0]      disp_src_a_i,
  input  logic [DISP_W-1:0][TAG_W-1:0]      disp_src_b_i,
  input  logic [DISP_W-1:0][TAG_W-1:0]      disp_dst_i,
  input  logic [WB_W-1:0]                   wb_vld_i,
  input  logic [WB_W-1:0][TAG_W-1:0]        wb_tag_i,
  output logic [ALU_N-1:0]                  alu_vld_o,
  output logic [ALU_N-1:0][ID_W-1:0]        alu_id_o,
  output logic [ALU_N-1:0][TAG_W-1:0]       alu_dst_o,
  output logic                              ls_vld_o,
  output logic [ID_W-1:0]                   ls_id_o,
  output logic [TAG_W-1:0]                  ls_dst_o,
  output logic [INT_FW-1:0]                 int_free_o,
  output logic [ADR_FW-1:0]                 adr_free_o
);
  isq_ent_t [DISP_W-1:0] disp_ent, int_ins, adr_ins;
  logic     [DISP_W-1:0] acc;
  logic     [CNT_W-1:0]  int_cnt, adr_cnt;
  logic     [NREG-1:0]   busy;
  isq_ent_t [ALU_N-1:0]  alu_ent;
  logic     [0:0]        ls_vld;
  isq_ent_t [0:0]        ls_ent;

  for (genvar j = 0; j < DISP_W; j++) begin : g_pack
    assign disp_ent[j] = '{id: disp_id_i[j], src_a: disp_src_a_i[j],
                           src_b: disp_src_b_i[j], dst: disp_dst_i[j]};
  end

  isq_route #(.DISP_W(DISP_W), .INT_FW(INT_FW), .ADR_FW(ADR_FW)) u_route (
    .clk_i, .rst_ni,
    .disp_vld_i, .disp_mem_i,
    .disp_ent_i (disp_ent),
    .int_free_i (int_free_o),
    .adr_free_i (adr_free_o),
    .acc_o      (acc),
    .int_cnt_o  (int_cnt),
    .int_ent_o  (int_ins),
    .adr_cnt_o  (adr_cnt),
    .adr_ent_o  (adr_ins)
  );

  isq_scoreboard #(.SET_W(DISP_W), .CLR_W(WB_W)) u_sb (
    .clk_i, .rst_ni, .flush_i,
    .set_vld_i (acc),
    .set_tag_i (disp_dst_i),
    .clr_vld_i (wb_vld_i),
    .clr_tag_i (wb_tag_i),
    .busy_o    (busy)
  );

  isq_queue #(.DEPTH(INT_DEPTH), .INS_W(DISP_W), .ISS_W(ALU_N), .IN_ORDER(1'b0)) u_intq (
    .clk_i, .rst_ni, .flush_i,
    .ins_cnt_i (int_cnt),
    .ins_ent_i (int_ins),
    .busy_i    (busy),
    .iss_vld_o (alu_vld_o),
    .iss_ent_o (alu_ent),
    .free_o    (int_free_o)
  );

  isq_queue #(.DEPTH(ADR_DEPTH), .INS_W(DISP_W), .ISS_W(1), .IN_ORDER(1'b1)) u_adrq (
    .clk_i, .rst_ni, .flush_i,
    .ins_cnt_i (adr_cnt),
    .ins_ent_i (adr_ins),
    .busy_i    (busy),
    .iss_vld_o (ls_vld),
    .iss_ent_o (ls_ent),
    .free_o    (adr_free_o)
  );

  for (genvar k = 0; k < ALU_N; k++) begin : g_alu
    assign alu_id_o[k]  = alu_ent[k].id;
    assign alu_dst_o[k] = alu_ent[k].dst;
  end

  assign ls_vld_o = ls_vld[0];
  assign ls_id_o  = ls_ent[0].id;
  assign ls_dst_o = ls_ent[0].dst;

  if (ALU_N > 1) begin : g_alu_chk
    AST_ALU_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alu_vld_o[0] && alu_vld_o[1] |-> alu_id_o[0] != alu_id_o[1]); // R3
  end
endmodule

// File: tb/split_issue_queue_tb_top.sv
`timescale 1ns/1ps
module split_issue_queue_tb_top;
  localparam int CLK_PERIOD = 10;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            flush_i;
  logic [3:0]      disp_vld, disp_mem;
  logic [3:0][7:0] disp_id;
  logic [3:0][4:0] disp_a, disp_b, disp_d;
  logic [1:0]      wb_vld;
  logic [1:0][4:0] wb_tag;
  logic [1:0]      alu_vld_o;
  logic [1:0][7:0] alu_id_o;
  logic [1:0][4:0] alu_dst_o;
  logic            ls_vld_o;
  logic [7:0]      ls_id_o;
  logic [4:0]      ls_dst_o;
  logic [3:0]      int_free_o, adr_free_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int alu0_q[$];
  int alu1_q[$];
  int ls_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  split_issue_queue dut_i (
    .clk_i, .rst_ni, .flush_i,
    .disp_vld_i(disp_vld), .disp_mem_i(disp_mem), .disp_id_i(disp_id),
    .disp_src_a_i(disp_a), .disp_src_b_i(disp_b), .disp_dst_i(disp_d),
    .wb_vld_i(wb_vld), .wb_tag_i(wb_tag),
    .alu_vld_o, .alu_id_o, .alu_dst_o,
    .ls_vld_o, .ls_id_o, .ls_dst_o,
    .int_free_o, .adr_free_o
  );

  task automatic check(input string r, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", r, what, act, exp);
    end
  endtask

  task automatic clear_in();
    flush_i = 1'b0; disp_vld = '0; disp_mem = '0; disp_id = '0;
    disp_a = '0; disp_b = '0; disp_d = '0; wb_vld = '0; wb_tag = '0;
  endtask

  task automatic put(input int s, input bit m, input int id, input int a, input int b, input int d);
    disp_vld[s] = 1'b1; disp_mem[s] = m; disp_id[s] = 8'(id);
    disp_a[s] = 5'(a); disp_b[s] = 5'(b); disp_d[s] = 5'(d);
  endtask

  task automatic wb(input int p, input int tag);
    wb_vld[p] = 1'b1; wb_tag[p] = 5'(tag);
  endtask

  // inputs change at negedge+1, the monitor samples at negedge+2
  task automatic step();
    @(negedge clk_i);
    clear_in();
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: pop the expected id for every issue that appears
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (rst_ni) begin
        if (alu_vld_o[0]) begin
          if (alu0_q.size() == 0) check("R3", "unexpected alu0 issue id", int'(alu_id_o[0]), -1);
          else check("R2", "alu0 issue id", int'(alu_id_o[0]), alu0_q.pop_front());
        end
        if (alu_vld_o[1]) begin
          if (alu1_q.size() == 0) check("R3", "unexpected alu1 issue id", int'(alu_id_o[1]), -1);
          else check("R3", "alu1 issue id", int'(alu_id_o[1]), alu1_q.pop_front());
        end
        if (ls_vld_o) begin
          if (ls_q.size() == 0) check("R4", "unexpected ls issue id", int'(ls_id_o), -1);
          else check("R4", "ls issue id", int'(ls_id_o), ls_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    clear_in();
    @(negedge clk_i); @(negedge clk_i); #1;
    // R1 reset state
    check("R1", "int free in reset", int'(int_free_o), 8);
    check("R1", "adr free in reset", int'(adr_free_o), 8);
    check("R1", "alu valid in reset", int'(alu_vld_o), 0);
    check("R1", "ls valid in reset", int'(ls_vld_o), 0);
    rst_ni = 1'b1;
    step();
    check("R1", "int free after reset", int'(int_free_o), 8);

    // A: out-of-order pick, oldest two, wakeup timing
    put(0, 0, 10, 1, 2, 20); put(1, 0, 11, 20, 3, 21);
    put(2, 0, 12, 4, 5, 22); put(3, 0, 13, 6, 7, 23);
    alu0_q.push_back(10); alu1_q.push_back(12); alu0_q.push_back(13);
    step();
    check("R8", "int free after four inserts", int'(int_free_o), 4);
    check("R3", "two alu valids", int'(alu_vld_o), 3);
    check("R7", "alu0 gets slot0 id", int'(alu_id_o[0]), 10);
    check("R3", "alu1 gets next oldest ready", int'(alu_id_o[1]), 12);
    step();
    check("R2", "younger ready passes blocked older", int'(alu_vld_o), 1);
    check("R2", "younger id on alu0", int'(alu_id_o[0]), 13);
    check("R8", "int free after issue", int'(int_free_o), 6);
    step();
    check("R5", "blocked entry waits", int'(alu_vld_o), 0);
    wb(0, 20);
    alu0_q.push_back(11);
    #0;
    check("R6", "no issue in broadcast cycle", int'(alu_vld_o), 0);
    step();
    check("R6", "woken entry issues next cycle", int'(alu_vld_o), 1);
    check("R6", "woken id", int'(alu_id_o[0]), 11);
    wb(0, 21); wb(1, 22);
    step();
    check("R8", "int free back to full", int'(int_free_o), 8);
    wb(0, 23);
    step();

    // B: mixed slots, in-order address queue
    put(0, 0, 29, 1, 2, 25); put(1, 1, 30, 25, 0, 26);
    put(2, 1, 31, 1, 2, 27); put(3, 0, 32, 1, 1, 28);
    alu0_q.push_back(29); alu1_q.push_back(32);
    ls_q.push_back(30); ls_q.push_back(31);
    step();
    check("R7", "int free after split dispatch", int'(int_free_o), 6);
    check("R7", "adr free after split dispatch", int'(adr_free_o), 6);
    check("R7", "both int entries issue", int'(alu_vld_o), 3);
    check("R4", "ready younger waits behind head", int'(ls_vld_o), 0);
    step();
    check("R4", "head still blocked", int'(ls_vld_o), 0);
    wb(0, 25);
    step();
    check("R4", "head issues after wakeup", int'(ls_vld_o), 1);
    check("R4", "head id", int'(ls_id_o), 30);
    step();
    check("R4", "second in order", int'(ls_id_o), 31);
    step();
    check("R8", "adr free back to full", int'(adr_free_o), 8);

    // C: partial acceptance and overfill
    flush_i = 1'b1;
    step();
    check("R10", "int free after flush", int'(int_free_o), 8);
    put(0, 0, 40, 1, 1, 30);
    alu0_q.push_back(40);
    step();
    put(0, 0, 41, 30, 30, 10); put(1, 0, 42, 30, 30, 11);
    put(2, 0, 43, 30, 30, 12); put(3, 0, 44, 30, 30, 13);
    step();
    check("R8", "int free with four waiting", int'(int_free_o), 4);
    put(0, 0, 45, 30, 30, 14); put(1, 0, 46, 30, 30, 15); put(2, 0, 47, 30, 30, 16);
    step();
    check("R8", "int free one left", int'(int_free_o), 1);
    put(0, 0, 48, 30, 30, 17); put(1, 0, 49, 30, 30, 18);
    put(2, 0, 50, 30, 30, 19); put(3, 1, 51, 1, 2, 9);
    ls_q.push_back(51);
    step();
    check("R9", "only one of three accepted", int'(int_free_o), 0);
    check("R9", "address slot accepted beside full int", int'(adr_free_o), 7);
    put(0, 0, 52, 1, 1, 20);
    step();
    check("R9", "full queue ignores dispatch", int'(int_free_o), 0);
    check("R9", "ignored ready entry not issued", int'(alu_vld_o), 0);
    wb(0, 30);
    alu0_q.push_back(41); alu1_q.push_back(42);
    alu0_q.push_back(43); alu1_q.push_back(44);
    alu0_q.push_back(45); alu1_q.push_back(46);
    alu0_q.push_back(47); alu1_q.push_back(48);
    step();
    check("R3", "eight ready, two issue", int'(alu_vld_o), 3);
    check("R3", "oldest on alu0", int'(alu_id_o[0]), 41);
    step(); step(); step(); step();
    check("R8", "drained int queue", int'(int_free_o), 8);

    // D: flush
    put(0, 0, 59, 1, 1, 31);
    alu0_q.push_back(59);
    step();
    put(0, 0, 60, 1, 2, 21); put(1, 0, 61, 3, 4, 22); put(2, 1, 62, 31, 31, 23);
    step();
    flush_i = 1'b1;
    put(0, 0, 63, 1, 1, 24);
    #0;
    check("R10", "alu quiet during flush", int'(alu_vld_o), 0);
    check("R10", "int occupied before flush", int'(int_free_o), 6);
    step();
    check("R10", "int free after flush", int'(int_free_o), 8);
    check("R10", "adr free after flush", int'(adr_free_o), 8);
    check("R10", "dispatch in flush cycle dropped", int'(alu_vld_o), 0);
    put(0, 1, 64, 31, 31, 25);
    ls_q.push_back(64);
    step();
    check("R10", "scoreboard cleared by flush", int'(ls_vld_o), 1);
    step(); step();

    check("R2", "alu0 expected left", alu0_q.size(), 0);
    check("R3", "alu1 expected left", alu1_q.size(), 0);
    check("R4", "ls expected left", ls_q.size(), 0);
    finish_run();
  end
endmodule